// File: doc/BRIEF.md
# Multi-core idle state coordinator

This block turns the idle requests of hardware threads into core idle states, and the core states into one package idle state. Each thread asks for active, halt, sleep or deep power-down. A core can go no deeper than its shallowest thread. The package follows the cores, but only while the platform grants low-power entry.

Before a core drops to deep power-down, its context must be saved. The block raises a save request and waits for the save-done acknowledge. Only then does it enable power-off for that core. A break event aimed at one core does three things: it pulls the package back to active, restores power to that core only, and forwards the event to that core once it is released to run. The voltage regulator gets a deep-sleep flag while the package sits in deep power-down.

Top module: `idle_coord`

## Requirements
- R1: Thread requests use the encoding 0=C0, 1=C1, 2=C3, 3=C6. Core k thread t sits at bits [(k*2+t)*2 +: 2] of `thr_req_i`. A core's resolved state is the shallowest of its two threads, in core encoding 0=C0, 1=C1, 2=C1E, 3=C3, 4=C6. It appears on `core_state_o[k*3 +: 3]` one cycle after the request.
- R2: With `c1e_en_i` high, a core that resolves to C1 reports C1E (2) only when every core resolves to C1 or deeper. Otherwise it reports C1.
- R3: The package state uses the encoding 0=C0, 1=C3, 2=C6. The package state is C0 whenever the grant was low in the previous cycle, or whenever any registered core state is C0, C1 or C1E.
- R4: The package state is C3 when the grant is high, every core is in C3 or C6, and at least one core is in C3.
- R5: The package state is C6 when the grant is high and every core is in C6.
- R6: A core that requests C6 first reports C3 and raises `save_req_o`. Its `pwr_off_o` rises only on the edge after `save_done_i` is seen with the request high, and the core then reports C6.
- R7: If a core's request becomes shallower than C6 while it is saving, the save request drops and the core takes the new state without powering off.
- R8: A break on a core forces the package to C0 on the next edge. It activates only the targeted core; other cores keep their state and their power-off.
- R9: A powered-off core that wakes drops `pwr_off_o` and reports C0 one cycle before it is released. On release, a pending break is forwarded as a one-cycle pulse on `evt_fwd_o`. A break on a running core is forwarded on the next edge.
- R10: `vr_deep_o` is high exactly while the package state is C6.
- R11: After reset, all core states and the package state are C0, and save, power-off, forward and deep outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_req_i | input | 8 | Per-thread idle request, 2 bits each |
| c1e_en_i | input | 1 | Enables C1 to C1E promotion |
| plat_grant_i | input | 1 | Platform permission for package low power |
| brk_i | input | 2 | Break event per core |
| save_done_i | input | 2 | Context save complete per core |
| core_state_o | output | 6 | Resolved state per core, 3 bits each |
| pkg_state_o | output | 2 | Package idle state |
| save_req_o | output | 2 | Context save request per core |
| pwr_off_o | output | 2 | Power-off enable per core |
| evt_fwd_o | output | 2 | Break event forwarded to released core |
| vr_deep_o | output | 1 | Deep-sleep indication to the regulator |

## Verification
The hardest situation to reach is a break that arrives while every core is powered off and the package is in C6. The wake path, the release cycle and the forwarding pulse must then line up, while the untouched core stays off. The stimulus gets there by holding save-done high until both cores reach C6 under grant. It then drops save-done so that re-entry stalls visibly, and pulses one core's break for a single cycle. A full sweep of all thread request combinations, with and without promotion and grant, covers the resolution and package rules from settled states.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;

    localparam int unsigned REQ_W = 2;
    localparam int unsigned CS_W  = 3;
    localparam int unsigned PK_W  = 2;

    typedef enum logic [REQ_W-1:0] {TREQ_C0 = 2'd0, TREQ_C1 = 2'd1, TREQ_C3 = 2'd2, TREQ_C6 = 2'd3} treq_e;

    typedef enum logic [CS_W-1:0] {
        CS_C0 = 3'd0, CS_C1 = 3'd1, CS_C1E = 3'd2, CS_C3 = 3'd3, CS_C6 = 3'd4
    } cstate_e;

    typedef enum logic [PK_W-1:0] {PK_C0 = 2'd0, PK_C3 = 2'd1, PK_C6 = 2'd2} pstate_e;

    typedef enum logic [1:0] {SQ_RUN, SQ_SAVE, SQ_OFF, SQ_WAKE} seq_e;

    function automatic cstate_e treq_to_cs(logic [REQ_W-1:0] r);
        case (r)
            2'd0:    return CS_C0;
            2'd1:    return CS_C1;
            2'd2:    return CS_C3;
            default: return CS_C6;
        endcase
    endfunction

endpackage

// File: rtl/thread_resolve.sv
module thread_resolve
    import idle_coord_pkg::*;
#(
    parameter int unsigned THREADS = 2
) (
    input  logic [THREADS*REQ_W-1:0] req_i,
    input  logic                     brk_i,
    output cstate_e                  raw_o
);
    logic [REQ_W-1:0] shallow;

    always_comb begin
        shallow = req_i[REQ_W-1:0];
        for (int t = 1; t < THREADS; t++) begin
            if (req_i[t*REQ_W +: REQ_W] < shallow)
                shallow = req_i[t*REQ_W +: REQ_W];
        end
        raw_o = brk_i ? CS_C0 : treq_to_cs(shallow);
    end
endmodule

// File: rtl/core_seq.sv
module core_seq
    import idle_coord_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cstate_e tgt_i,
    input  logic    brk_i,
    input  logic    save_done_i,
    output cstate_e cs_o,
    output logic    save_req_o,
    output logic    pwr_off_o,
    output logic    fwd_o
);
    seq_e st;
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_RUN;
            cs_o  <= CS_C0;
            fwd_o <= 1'b0;
            pend  <= 1'b0;
        end else begin
            fwd_o <= 1'b0;
            case (st)
                SQ_RUN: begin
                    if (tgt_i == CS_C6) begin
                        st   <= SQ_SAVE;
                        cs_o <= CS_C3;
                    end else begin
                        cs_o  <= tgt_i;
                        fwd_o <= brk_i;
                    end
                end
                SQ_SAVE: begin
                    if (tgt_i != CS_C6) begin
                        st    <= SQ_RUN;
                        cs_o  <= tgt_i;
                        fwd_o <= brk_i;
                    end else if (save_done_i) begin
                        st   <= SQ_OFF;
                        cs_o <= CS_C6;
                    end
                end
                SQ_OFF: begin
                    if (tgt_i != CS_C6) begin
                        st   <= SQ_WAKE;
                        cs_o <= CS_C0;
                        pend <= brk_i;
                    end
                end
                default: begin
                    st    <= SQ_RUN;
                    cs_o  <= CS_C0;
                    fwd_o <= pend | brk_i;
                    pend  <= 1'b0;
                end
            endcase
        end
    end

    assign save_req_o = (st == SQ_SAVE);
    assign pwr_off_o  = (st == SQ_OFF);
endmodule

// File: rtl/pkg_arbiter.sv
module pkg_arbiter
    import idle_coord_pkg::*;
#(
    parameter int unsigned N_CORES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CORES*CS_W-1:0] cs_i,
    input  logic                    grant_i,
    input  logic [N_CORES-1:0]      brk_i,
    output pstate_e                 pk_o
);
    pstate_e nxt;
    logic any_shallow;
    logic all_c6;

    always_comb begin
        any_shallow = 1'b0;
        all_c6      = 1'b1;
        for (int k = 0; k < N_CORES; k++) begin
            if (cs_i[k*CS_W +: CS_W] < CS_C3) any_shallow = 1'b1;
            if (cs_i[k*CS_W +: CS_W] != CS_C6) all_c6 = 1'b0;
        end
        if (!grant_i || (|brk_i) || any_shallow) nxt = PK_C0;
        else if (all_c6)                         nxt = PK_C6;
        else                                     nxt = PK_C3;
    end

    always_ff @(posedge clk) begin
        if (rst) pk_o <= PK_C0;
        else     pk_o <= nxt;
    end
endmodule

// File: rtl/idle_coord.sv
module idle_coord
    import idle_coord_pkg::*;
#(
    parameter int unsigned N_CORES = 2,
    parameter int unsigned THREADS = 2,
    localparam int unsigned REQ_BITS = N_CORES * THREADS * REQ_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [REQ_BITS-1:0]     thr_req_i,
    input  logic                    c1e_en_i,
    input  logic                    plat_grant_i,
    input  logic [N_CORES-1:0]      brk_i,
    input  logic [N_CORES-1:0]      save_done_i,
    output logic [N_CORES*CS_W-1:0] core_state_o,
    output logic [PK_W-1:0]         pkg_state_o,
    output logic [N_CORES-1:0]      save_req_o,
    output logic [N_CORES-1:0]      pwr_off_o,
    output logic [N_CORES-1:0]      evt_fwd_o,
    output logic                    vr_deep_o
);
    cstate_e raw [N_CORES];
    cstate_e tgt [N_CORES];
    cstate_e cs  [N_CORES];
    logic    all_ge1;
    pstate_e pk;

    always_comb begin
        all_ge1 = 1'b1;
        for (int k = 0; k < N_CORES; k++)
            if (raw[k] == CS_C0) all_ge1 = 1'b0;
    end

    for (genvar k = 0; k < N_CORES; k++) begin : g_core
        thread_resolve #(.THREADS(THREADS)) u_res (
            .req_i (thr_req_i[k*THREADS*REQ_W +: THREADS*REQ_W]),
            .brk_i (brk_i[k]),
            .raw_o (raw[k])
        );

        assign tgt[k] = (raw[k] == CS_C1 && c1e_en_i && all_ge1) ? CS_C1E : raw[k];

        core_seq u_seq (
            .clk         (clk),
            .rst         (rst),
            .tgt_i       (tgt[k]),
            .brk_i       (brk_i[k]),
            .save_done_i (save_done_i[k]),
            .cs_o        (cs[k]),
            .save_req_o  (save_req_o[k]),
            .pwr_off_o   (pwr_off_o[k]),
            .fwd_o       (evt_fwd_o[k])
        );

        assign core_state_o[k*CS_W +: CS_W] = cs[k];
    end

    pkg_arbiter #(.N_CORES(N_CORES)) u_pkg (
        .clk     (clk),
        .rst     (rst),
        .cs_i    (core_state_o),
        .grant_i (plat_grant_i),
        .brk_i   (brk_i),
        .pk_o    (pk)
    );

    assign pkg_state_o = pk;
    assign vr_deep_o   = (pk == PK_C6);
endmodule

// File: rtl/idle_coord_chk.sv
module idle_coord_chk #(
    parameter int unsigned N_CORES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 plat_grant_i,
    input logic [N_CORES-1:0]   brk_i,
    input logic [N_CORES-1:0]   save_done_i,
    input logic [N_CORES*3-1:0] core_state_o,
    input logic [1:0]           pkg_state_o,
    input logic [N_CORES-1:0]   save_req_o,
    input logic [N_CORES-1:0]   pwr_off_o,
    input logic [N_CORES-1:0]   evt_fwd_o,
    input logic                 vr_deep_o
);
    logic all_c6;
    always_comb begin
        all_c6 = 1'b1;
        for (int k = 0; k < N_CORES; k++)
            if (core_state_o[k*3 +: 3] != 3'd4) all_c6 = 1'b0;
    end

    p_no_grant_c0_r3: assert property (@(posedge clk) disable iff (rst)
        !plat_grant_i |=> pkg_state_o == 2'd0);

    p_brk_pkg_c0_r8: assert property (@(posedge clk) disable iff (rst)
        (|brk_i) |=> pkg_state_o == 2'd0);

    p_deep_after_all_c6_r10: assert property (@(posedge clk) disable iff (rst)
        vr_deep_o |-> $past(all_c6 && plat_grant_i && !(|brk_i)));

    for (genvar k = 0; k < N_CORES; k++) begin : g_chk
        p_off_after_save_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(pwr_off_o[k]) |-> $past(save_req_o[k] && save_done_i[k]));

        p_save_off_excl_r6: assert property (@(posedge clk) disable iff (rst)
            !(save_req_o[k] && pwr_off_o[k]));

        p_wake_reports_c0_r9: assert property (@(posedge clk) disable iff (rst)
            $fell(pwr_off_o[k]) |-> core_state_o[k*3 +: 3] == 3'd0);

        p_fwd_powered_r9: assert property (@(posedge clk) disable iff (rst)
            evt_fwd_o[k] |-> (!pwr_off_o[k] && !$past(pwr_off_o[k]) && core_state_o[k*3 +: 3] == 3'd0));
    end
endmodule

bind idle_coord idle_coord_chk #(.N_CORES(N_CORES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .plat_grant_i (plat_grant_i),
    .brk_i        (brk_i),
    .save_done_i  (save_done_i),
    .core_state_o (core_state_o),
    .pkg_state_o  (pkg_state_o),
    .save_req_o   (save_req_o),
    .pwr_off_o    (pwr_off_o),
    .evt_fwd_o    (evt_fwd_o),
    .vr_deep_o    (vr_deep_o)
);

// File: tb/test_idle_coord.sv
module test_idle_coord;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] thr_req_i;
    logic       c1e_en_i;
    logic       plat_grant_i;
    logic [1:0] brk_i;
    logic [1:0] save_done_i;
    logic [5:0] core_state_o;
    logic [1:0] pkg_state_o;
    logic [1:0] save_req_o;
    logic [1:0] pwr_off_o;
    logic [1:0] evt_fwd_o;
    logic       vr_deep_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    idle_coord i_idle_coord (
        .clk(clk), .rst(rst), .thr_req_i(thr_req_i), .c1e_en_i(c1e_en_i),
        .plat_grant_i(plat_grant_i), .brk_i(brk_i), .save_done_i(save_done_i),
        .core_state_o(core_state_o), .pkg_state_o(pkg_state_o), .save_req_o(save_req_o),
        .pwr_off_o(pwr_off_o), .evt_fwd_o(evt_fwd_o), .vr_deep_o(vr_deep_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int raw_of(logic [7:0] thr, int k);
        int a = int'(thr[k*4 +: 2]);
        int b = int'(thr[k*4+2 +: 2]);
        int m = (a < b) ? a : b;
        return (m >= 2) ? m + 1 : m;
    endfunction

    function automatic int exp_core(logic [7:0] thr, int k, bit c1e);
        int r = raw_of(thr, k);
        bit ge1 = (raw_of(thr, 0) != 0) && (raw_of(thr, 1) != 0);
        return (r == 1 && c1e && ge1) ? 2 : r;
    endfunction

    function automatic int exp_pkg(logic [7:0] thr, bit c1e, bit g);
        int c0 = exp_core(thr, 0, c1e);
        int c1 = exp_core(thr, 1, c1e);
        if (!g || c0 < 3 || c1 < 3) return 0;
        if (c0 == 4 && c1 == 4) return 2;
        return 1;
    endfunction

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; thr_req_i = '0; c1e_en_i = 1'b0; plat_grant_i = 1'b0;
        brk_i = '0; save_done_i = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R11 reset state
        check("R11 core", int'(core_state_o), 0);
        check("R11 pkg", int'(pkg_state_o), 0);
        check("R11 save/off/fwd", int'({save_req_o, pwr_off_o, evt_fwd_o}), 0);
        check("R11 deep", int'(vr_deep_o), 0);

        // R1 R2 R3 R4 R5 R10 sweep of all settled combinations, save acked at once
        save_done_i = 2'b11;
        for (int code = 0; code < 1024; code++) begin
            logic [9:0] cv = code[9:0];
            thr_req_i = cv[7:0]; c1e_en_i = cv[8]; plat_grant_i = cv[9];
            repeat (6) tick();
            for (int k = 0; k < 2; k++) begin
                int ec = exp_core(cv[7:0], k, cv[8]);
                check("R1 R2 core state", int'(core_state_o[k*3 +: 3]), ec);
                check("R6 settled power-off", int'(pwr_off_o[k]), (ec == 4) ? 1 : 0);
            end
            check("R3 R4 R5 package", int'(pkg_state_o), exp_pkg(cv[7:0], cv[8], cv[9]));
            check("R10 deep", int'(vr_deep_o), (exp_pkg(cv[7:0], cv[8], cv[9]) == 2) ? 1 : 0);
            check("R6 settled save", int'(save_req_o), 0);
        end

        // R6 save handshake gates power-off
        thr_req_i = 8'h00; c1e_en_i = 1'b0; plat_grant_i = 1'b1; save_done_i = 2'b00;
        repeat (6) tick();
        thr_req_i = 8'h0F;
        tick();
        check("R6 saving state", int'(core_state_o[2:0]), 3);
        check("R6 save req", int'(save_req_o), 1);
        repeat (3) tick();
        check("R6 no off before ack", int'(pwr_off_o), 0);
        save_done_i = 2'b01;
        tick();
        save_done_i = 2'b00;
        check("R6 off after ack", int'(pwr_off_o), 1);
        check("R6 C6 after ack", int'(core_state_o[2:0]), 4);
        check("R6 save dropped", int'(save_req_o), 0);

        // R7 abort a save
        thr_req_i = 8'hFF;
        tick();
        check("R7 core1 saving", int'(save_req_o[1]), 1);
        thr_req_i = 8'h5F;
        tick();
        check("R7 save aborted", int'(save_req_o[1]), 0);
        check("R7 new state", int'(core_state_o[5:3]), 1);
        check("R7 no power-off", int'(pwr_off_o[1]), 0);

        // R8 R9 break while package in C6
        thr_req_i = 8'hFF; save_done_i = 2'b11;
        repeat (6) tick();
        check("R5 both off", int'(pkg_state_o), 2);
        check("R10 deep set", int'(vr_deep_o), 1);
        save_done_i = 2'b00;
        brk_i = 2'b10;
        tick();
        brk_i = 2'b00;
        check("R8 pkg woke", int'(pkg_state_o), 0);
        check("R10 deep cleared", int'(vr_deep_o), 0);
        check("R8 other core stays off", int'(pwr_off_o), 1);
        check("R8 other core C6", int'(core_state_o[2:0]), 4);
        check("R9 power restored C0", int'(core_state_o[5:3]), 0);
        check("R9 no fwd before release", int'(evt_fwd_o), 0);
        tick();
        check("R9 forwarded on release", int'(evt_fwd_o), 2);
        check("R9 released C0", int'(core_state_o[5:3]), 0);
        tick();
        check("R9 fwd one pulse", int'(evt_fwd_o), 0);
        check("R9 re-saving", int'(save_req_o), 2);

        // R8 break in package C3 touches only target
        thr_req_i = 8'hAA; save_done_i = 2'b00;
        repeat (6) tick();
        check("R4 pkg C3", int'(pkg_state_o), 1);
        brk_i = 2'b01;
        tick();
        brk_i = 2'b00;
        check("R8 pkg C0", int'(pkg_state_o), 0);
        check("R9 running fwd", int'(evt_fwd_o), 1);
        check("R8 core0 active", int'(core_state_o[2:0]), 0);
        check("R8 core1 untouched", int'(core_state_o[5:3]), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule